// File: doc/BRIEF.md
# Keyed Watchdog Timer with Early-Warning Threshold

This block is a bus-attached watchdog built around a 32-bit down-counter. Software loads a count, turns the counter on, and must keep reloading it ("kicking") before the count runs out. Each cycle in which the `tickEn` input is high and the watchdog is on, the count drops by one. A programmable threshold raises an early-warning interrupt when the falling count reaches it, and a separate timeout interrupt fires when the count hits zero. The timeout output only signals; what it resets is decided elsewhere.

Writes are guarded against runaway software. Each write to a functional register is accepted only if the bus write just before it put the unlock key into the key register. A wrong key re-locks the block, and each correct key allows exactly one write. Both interrupt flags live in one status word. They stay set until software clears them by writing ones to their bits, and that write also needs the key.

Top module: `keyed_wdog`

Address map (byte offsets): 0x00 count, 0x04 threshold, 0x08 enable (bit 0), 0x0C key, 0x10 status. Unlock key value is 0xF1D0DEAD.

## Requirements
- R1: After reset the count, threshold, enable and both flags read as 0, both interrupt outputs are low, and the block is locked.
- R2: Writing 0xF1D0DEAD to offset 0x0C unlocks the block for exactly one following bus write to any other offset. That write uses up the unlock whether or not it lands on a mapped register. Reads do not affect the unlock.
- R3: A write to 0x00, 0x04, 0x08 or 0x10 while the block is locked has no effect. Writing any value other than the key to 0x0C locks the block again.
- R4: When enable bit 0 at 0x08 is 1, the count drops by exactly one on each clock in which `tickEn` is high. While enable is 0 the count holds its value.
- R5: An accepted write to 0x00 loads the count with the write data. This load takes priority over a tick in the same cycle. Reading 0x00 returns the current count.
- R6: The count never wraps. Once it reaches 0 it stays at 0 through further ticks until it is reloaded.
- R7: The timeout flag (status bit 8) sets when a tick moves the count from 1 to 0. `irqTimeout` follows this flag.
- R8: The threshold flag (status bit 9) sets when a tick brings the count down to the nonzero value held at 0x04. `irqThresh` follows this flag. A threshold of 0 never sets it, and loading a count below the threshold does not set it.
- R9: A set flag stays set until an accepted write to 0x10 with a 1 in that flag's bit. A 0 bit leaves its flag unchanged.
- R10: Reading 0x04 returns the threshold, 0x08 returns enable in bit 0, and 0x10 returns the flags at bits 9 and 8. Reading the key offset or any unmapped offset returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 5 | Register byte offset |
| busWe | input | 1 | Write strobe, one write per cycle |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for `busAddr`, combinational |
| tickEn | input | 1 | Count-rate pulse |
| irqThresh | output | 1 | Early-warning interrupt level |
| irqTimeout | output | 1 | Timeout interrupt level |

## Verification
The assertions check, on every cycle, the rules that depend on only one or two cycles. A non-key write always uses up the unlock. A locked write never produces a strobe. The count holds while disabled and sticks at zero. A reload lands exactly. The timeout flag sets on the step from 1 to 0, and a flag persists until a matching clear. The bench scenarios cover the behaviour that only shows up across sequences: a second write after one key is refused, a wrong key closes an open unlock, the threshold crossing happens at the right tick count, a reload below the threshold does not fire the warning, a threshold of 0 stays silent, and a reload wins over a tick in the same cycle.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int unsigned OFF_COUNT  = 'h00;
  localparam int unsigned OFF_THRESH = 'h04;
  localparam int unsigned OFF_ENABLE = 'h08;
  localparam int unsigned OFF_KEY    = 'h0C;
  localparam int unsigned OFF_STATUS = 'h10;
  localparam logic [31:0] UNLOCK_KEY = 32'hF1D0_DEAD;
  localparam int unsigned BIT_TIMEOUT = 8;
  localparam int unsigned BIT_THRESH  = 9;

  typedef struct packed {
    logic loadCount;
    logic loadThresh;
    logic loadEnable;
    logic clrStatus;
  } wdogStrobes_t;
endpackage

// File: rtl/wdog_ctrl.sv
module wdog_ctrl
  import wdog_pkg::*;
#(
  parameter int unsigned ADDR_W = 5,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic [DATA_W-1:0] busWdata,
  output wdogStrobes_t      strobes
);
  localparam logic [ADDR_W-1:0] A_COUNT  = ADDR_W'(OFF_COUNT);
  localparam logic [ADDR_W-1:0] A_THRESH = ADDR_W'(OFF_THRESH);
  localparam logic [ADDR_W-1:0] A_ENABLE = ADDR_W'(OFF_ENABLE);
  localparam logic [ADDR_W-1:0] A_KEY    = ADDR_W'(OFF_KEY);
  localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(OFF_STATUS);
  localparam logic [DATA_W-1:0] KEY_VAL  = DATA_W'(UNLOCK_KEY);

  logic unlocked;
  logic isKeyAddr;
  logic keyMatch;

  assign isKeyAddr = (busAddr == A_KEY);
  assign keyMatch  = (busWdata == KEY_VAL);

  // A key write opens or closes; any other write spends the unlock.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      unlocked <= 1'b0;
    end else if (busWe) begin
      if (isKeyAddr) unlocked <= keyMatch;
      else           unlocked <= 1'b0;
    end
  end

  always_comb begin
    strobes = '0;
    if (busWe && unlocked && !isKeyAddr) begin
      unique case (busAddr)
        A_COUNT:  strobes.loadCount  = 1'b1;
        A_THRESH: strobes.loadThresh = 1'b1;
        A_ENABLE: strobes.loadEnable = 1'b1;
        A_STATUS: strobes.clrStatus  = 1'b1;
        default:  strobes = '0;
      endcase
    end
  end

  // R2: a non-key write always leaves the block locked afterwards
  a_r2_unlock_spent: assert property (@(posedge clk) disable iff (!rstN)
    (busWe && !isKeyAddr) |=> !unlocked);

  // R3: nothing reaches the datapath while locked
  a_r3_locked_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (!unlocked) |-> (strobes == '0));

  // R3: a wrong key closes the unlock
  a_r3_bad_key_locks: assert property (@(posedge clk) disable iff (!rstN)
    (busWe && isKeyAddr && !keyMatch) |=> !unlocked);

  // R2: at most one register targeted per write
  a_r2_single_target: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strobes));
endmodule

// File: rtl/wdog_dpath.sv
module wdog_dpath
  import wdog_pkg::*;
#(
  parameter int unsigned ADDR_W = 5,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  wdogStrobes_t      strobes,
  input  logic [DATA_W-1:0] busWdata,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              tickEn,
  output logic [DATA_W-1:0] busRdata,
  output logic              irqThresh,
  output logic              irqTimeout
);
  localparam logic [ADDR_W-1:0] A_COUNT  = ADDR_W'(OFF_COUNT);
  localparam logic [ADDR_W-1:0] A_THRESH = ADDR_W'(OFF_THRESH);
  localparam logic [ADDR_W-1:0] A_ENABLE = ADDR_W'(OFF_ENABLE);
  localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(OFF_STATUS);

  logic [DATA_W-1:0] count;
  logic [DATA_W-1:0] thresh;
  logic              enable;
  logic              thFlag;
  logic              toFlag;
  logic              stepNow;
  logic [DATA_W-1:0] countDec;
  logic              thHit;
  logic              toHit;

  assign stepNow  = enable && tickEn && (count != '0) && !strobes.loadCount;
  assign countDec = count - DATA_W'(1);
  assign thHit    = stepNow && (thresh != '0) && (countDec == thresh);
  assign toHit    = stepNow && (countDec == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      count  <= '0;
      thresh <= '0;
      enable <= 1'b0;
    end else begin
      if (strobes.loadCount) count <= busWdata;
      else if (stepNow)      count <= countDec;
      if (strobes.loadThresh) thresh <= busWdata;
      if (strobes.loadEnable) enable <= busWdata[0];
    end
  end

  // Set wins over a clear in the same cycle.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      thFlag <= 1'b0;
      toFlag <= 1'b0;
    end else begin
      if (thHit) thFlag <= 1'b1;
      else if (strobes.clrStatus && busWdata[BIT_THRESH]) thFlag <= 1'b0;
      if (toHit) toFlag <= 1'b1;
      else if (strobes.clrStatus && busWdata[BIT_TIMEOUT]) toFlag <= 1'b0;
    end
  end

  always_comb begin
    busRdata = '0;
    unique case (busAddr)
      A_COUNT:  busRdata = count;
      A_THRESH: busRdata = thresh;
      A_ENABLE: busRdata[0] = enable;
      A_STATUS: begin
        busRdata[BIT_THRESH]  = thFlag;
        busRdata[BIT_TIMEOUT] = toFlag;
      end
      default:  busRdata = '0;
    endcase
  end

  assign irqThresh  = thFlag;
  assign irqTimeout = toFlag;

  // R4: disabled counter holds unless reloaded
  a_r4_hold_when_off: assert property (@(posedge clk) disable iff (!rstN)
    (!enable && !strobes.loadCount) |=> (count == $past(count)));

  // R5: a reload lands exactly, tick or not
  a_r5_reload_exact: assert property (@(posedge clk) disable iff (!rstN)
    strobes.loadCount |=> (count == $past(busWdata)));

  // R6: zero is sticky until a reload
  a_r6_zero_sticky: assert property (@(posedge clk) disable iff (!rstN)
    ((count == '0) && !strobes.loadCount) |=> (count == '0));

  // R7: stepping from one to zero raises the timeout flag
  a_r7_timeout_sets: assert property (@(posedge clk) disable iff (!rstN)
    (enable && tickEn && (count == DATA_W'(1)) && !strobes.loadCount) |=> irqTimeout);

  // R9: flags persist until a matching clear
  a_r9_timeout_holds: assert property (@(posedge clk) disable iff (!rstN)
    (toFlag && !(strobes.clrStatus && busWdata[BIT_TIMEOUT])) |=> toFlag);

  a_r9_thresh_holds: assert property (@(posedge clk) disable iff (!rstN)
    (thFlag && !(strobes.clrStatus && busWdata[BIT_THRESH])) |=> thFlag);
endmodule

// File: rtl/keyed_wdog.sv
module keyed_wdog
  import wdog_pkg::*;
#(
  parameter int unsigned ADDR_W = 5,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic              tickEn,
  output logic              irqThresh,
  output logic              irqTimeout
);
  wdogStrobes_t strobes;

  wdog_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .busAddr  (busAddr),
    .busWe    (busWe),
    .busWdata (busWdata),
    .strobes  (strobes)
  );

  wdog_dpath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) uDpath (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .busWdata   (busWdata),
    .busAddr    (busAddr),
    .tickEn     (tickEn),
    .busRdata   (busRdata),
    .irqThresh  (irqThresh),
    .irqTimeout (irqTimeout)
  );
endmodule

// File: tb/sim_keyed_wdog.sv
module sim_keyed_wdog;
  localparam logic [4:0]  A_CNT = 5'h00;
  localparam logic [4:0]  A_THR = 5'h04;
  localparam logic [4:0]  A_EN  = 5'h08;
  localparam logic [4:0]  A_KEY = 5'h0C;
  localparam logic [4:0]  A_ST  = 5'h10;
  localparam logic [31:0] KEY   = 32'hF1D0DEAD;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [4:0]  busAddr = '0;
  logic        busWe = 1'b0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        tickEn = 1'b0;
  logic        irqThresh;
  logic        irqTimeout;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #2.5 clk = ~clk;

  keyed_wdog u0 (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe),
    .busWdata(busWdata), .busRdata(busRdata), .tickEn(tickEn),
    .irqThresh(irqThresh), .irqTimeout(irqTimeout)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(logic [4:0] a, logic [31:0] d);
    @(negedge clk);
    busWe = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busWe = 1'b0; busWdata = '0;
  endtask

  task automatic kwr(logic [4:0] a, logic [31:0] d);
    wr(A_KEY, KEY);
    wr(a, d);
  endtask

  task automatic rdChk(string req, logic [4:0] a, logic [31:0] exp);
    busAddr = a;
    #1;
    check(req, busRdata, exp);
  endtask

  task automatic ticks(int n);
    @(negedge clk);
    tickEn = 1'b1;
    for (int i = 0; i < n; i++) @(negedge clk);
    tickEn = 1'b0;
  endtask

  task automatic t_reset;
    rdChk("R1 count", A_CNT, 0);
    rdChk("R1 thresh", A_THR, 0);
    rdChk("R1 enable", A_EN, 0);
    rdChk("R1 status", A_ST, 0);
    check("R1 irqs", {30'd0, irqThresh, irqTimeout}, 0);
    rdChk("R10 key reads zero", A_KEY, 0);
    rdChk("R10 unmapped reads zero", 5'h14, 0);
  endtask

  task automatic t_lock;
    wr(A_CNT, 100);
    rdChk("R3 locked write ignored", A_CNT, 0);
    kwr(A_CNT, 50);
    rdChk("R2 keyed write accepted", A_CNT, 50);
    wr(A_CNT, 70);
    rdChk("R2 unlock spent after one write", A_CNT, 50);
    wr(A_KEY, KEY);
    wr(A_KEY, 32'h1234_5678);
    wr(A_CNT, 9);
    rdChk("R3 wrong key relocks", A_CNT, 50);
    wr(A_KEY, KEY);
    wr(5'h18, 5);
    wr(A_CNT, 11);
    rdChk("R2 unmapped write spends unlock", A_CNT, 50);
    wr(A_KEY, KEY);
    rdChk("R2 read between key and write", A_THR, 0);
    wr(A_CNT, 40);
    rdChk("R2 read keeps unlock", A_CNT, 40);
  endtask

  task automatic t_count;
    kwr(A_EN, 1);
    rdChk("R10 enable reads back", A_EN, 1);
    ticks(5);
    rdChk("R4 five ticks", A_CNT, 35);
    kwr(A_EN, 0);
    ticks(3);
    rdChk("R4 hold while disabled", A_CNT, 35);
    kwr(A_EN, 1);
  endtask

  task automatic t_thresh;
    kwr(A_THR, 30);
    rdChk("R10 thresh reads back", A_THR, 30);
    ticks(4);
    rdChk("R4 count before threshold", A_CNT, 31);
    rdChk("R8 not yet crossed", A_ST, 0);
    ticks(1);
    rdChk("R8 crossing sets bit 9", A_ST, 32'h200);
    check("R8 irqThresh high", {31'd0, irqThresh}, 1);
    ticks(2);
    rdChk("R9 flag persists", A_ST, 32'h200);
    kwr(A_ST, 32'h100);
    rdChk("R9 other bit clear leaves flag", A_ST, 32'h200);
    wr(A_ST, 32'h200);
    rdChk("R3 locked clear ignored", A_ST, 32'h200);
    kwr(A_ST, 32'h200);
    rdChk("R9 clear by one", A_ST, 0);
  endtask

  task automatic t_timeout;
    kwr(A_CNT, 3);
    ticks(3);
    rdChk("R7 count reaches zero", A_CNT, 0);
    rdChk("R7 timeout bit 8 only (R8 no cross on reload)", A_ST, 32'h100);
    check("R7 irqTimeout high", {31'd0, irqTimeout}, 1);
    ticks(4);
    rdChk("R6 zero sticky", A_CNT, 0);
    kwr(A_ST, 32'h100);
    check("R9 timeout cleared", {31'd0, irqTimeout}, 0);
  endtask

  task automatic t_prio;
    wr(A_KEY, KEY);
    @(negedge clk);
    tickEn = 1'b1; busWe = 1'b1; busAddr = A_CNT; busWdata = 32'd20;
    @(negedge clk);
    busWe = 1'b0; tickEn = 1'b0;
    rdChk("R5 reload beats tick", A_CNT, 20);
    ticks(2);
    kwr(A_CNT, 20);
    rdChk("R5 kick reloads", A_CNT, 20);
  endtask

  task automatic t_zero_thresh;
    kwr(A_THR, 0);
    kwr(A_CNT, 3);
    ticks(3);
    rdChk("R8 zero threshold silent", A_ST, 32'h100);
    check("R8 irqThresh low", {31'd0, irqThresh}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_lock();
    t_count();
    t_thresh();
    t_timeout();
    t_prio();
    t_zero_thresh();
    done = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end
endmodule